// File: doc/BRIEF.md
# Three-phase modulating reference generator with third-harmonic injection

This block produces the three modulating references that a carrier-based multilevel PWM stage compares against its carriers. A 32-bit phase accumulator advances once per sample period. Its value sets the fundamental frequency: the increment is f_out·2^32/f_sample, so 50 Hz is one setting of it. A single sine table, addressed by the accumulator, gives each phase its fundamental term. The three fundamental terms are 120 degrees apart.

The table also gives one third-harmonic term. It is read at three times the accumulator angle. A whole number of turns separates the three phases at the third harmonic, so the same term is added to every phase. The sum is scaled by a modulation index and clamped to the signed 16-bit range. A mode input selects between two kinds of reference. With injection off, the references are plain scaled sines. With injection on, the third harmonic is added with a programmable coefficient; the intended coefficient range is roughly 0.15 to 0.2.

The accumulator increment, the modulation index, the coefficient and the mode are all captured at the sample boundary. A one-cycle strobe marks each new set of three samples.

Top module: `thi_ref_gen`

## Requirements
- R1: At each sample tick the phase advances by `phase_inc` modulo 2^32, using the increment present at that tick. The first sample after reset uses phase = `phase_inc`.
- R2: The fundamental term F for phase p is entry p[31:22] of a 1024-entry table. Entry i equals round(32767·sin(2π·i/1024)).
- R3: Phase A reads the table at p. Phase B reads it at p+0x5555_5555 and phase C at p+0xAAAA_AAAA, both modulo 2^32.
- R4: The harmonic term H is the table entry at index ((3·p) mod 2^32)[31:22]. The same H is used for all three phases.
- R5: With `inject_en`=1, each output is sat(floor(m·(F + floor(k·H/2^15))/2^15)). Here m=`mod_idx` and k=`harm_coef` are unsigned Q1.15.
- R6: With `inject_en`=0, `harm_coef` has no effect, and each output is sat(floor(m·F/2^15)).
- R7: Results outside [-32768, 32767] clamp to the nearest limit, so the output never wraps.
- R8: `ref_vld` is high for exactly one cycle every SAMPLE_DIV cycles. Between strobes, and after reset until the first strobe, the outputs hold (0 after reset).
- R9: Changes to `mod_idx`, `harm_coef` and `inject_en` made after a tick do not alter the sample already in flight. They first apply to the sample of the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_inc | input | 32 | Accumulator step per sample |
| mod_idx | input | 16 | Modulation index m, unsigned Q1.15 |
| harm_coef | input | 16 | Third-harmonic coefficient k, unsigned Q1.15 |
| inject_en | input | 1 | 1: add third harmonic, 0: plain sine |
| ref_a | output | 16 | Phase A reference, signed |
| ref_b | output | 16 | Phase B reference, signed |
| ref_c | output | 16 | Phase C reference, signed |
| ref_vld | output | 1 | One-cycle strobe for a new sample set |

## Verification
The bench builds the block with SAMPLE_DIV = 8 and keeps the 32-bit accumulator, 10-bit table address and 16-bit data widths at their defaults. With these values, hundreds of samples at arbitrary increments fit in a few thousand cycles, so the accumulator wraps many times and every table region is visited. The short period also leaves room for the pipeline of three registers and for a parameter change placed just after a tick, which exposes the sample-boundary rule. Indices up to 0xFFFF and large coefficients drive the sum past full scale and exercise the clamp on both sides.

// File: rtl/thi_pkg.sv
package thi_pkg;
  localparam int NPH = 3;

  // Rounded table entry: round(amp * sin(2*pi*idx / 2^aw))
  function automatic int sine_at(int idx, int aw, int dw);
    real ang;
    real amp;
    ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(1 << aw);
    amp = real'((1 << (dw - 1)) - 1);
    return int'(amp * $sin(ang));
  endfunction
endpackage

// File: rtl/thi_phase_acc.sv
module thi_phase_acc #(
  parameter int ACC_W      = 32,
  parameter int DW         = 16,
  parameter int SAMPLE_DIV = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [DW-1:0]    m_i,
  input  logic [DW-1:0]    k_i,
  input  logic             inj_i,
  output logic             tick_o,
  output logic [ACC_W-1:0] phase_o,
  output logic [DW-1:0]    m_o,
  output logic [DW-1:0]    k_o,
  output logic             inj_o
);
  localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] phase_q, phase_d;
  logic [DW-1:0]    m_q, m_d, k_q, k_d;
  logic             inj_q, inj_d;
  logic             tick;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d   = tick ? '0 : cnt_q + 1'b1;
    phase_d = phase_q;
    m_d     = m_q;
    k_d     = k_q;
    inj_d   = inj_q;
    if (tick) begin
      phase_d = phase_q + inc_i;
      m_d     = m_i;
      k_d     = k_i;
      inj_d   = inj_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
      m_q     <= '0;
      k_q     <= '0;
      inj_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      m_q     <= m_d;
      k_q     <= k_d;
      inj_q   <= inj_d;
    end
  end

  assign tick_o  = tick;
  assign phase_o = phase_q;
  assign m_o     = m_q;
  assign k_o     = k_q;
  assign inj_o   = inj_q;

  // R1: phase only moves at a tick
  p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_o));
  // R9: captured controls only change at a tick
  p_param_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(m_o) && $stable(k_o) && $stable(inj_o)));
endmodule

// File: rtl/thi_sine_rom.sv
module thi_sine_rom #(
  parameter int AW  = 10,
  parameter int DW  = 16,
  parameter int NRD = 4
) (
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_w[i] = DW'(thi_pkg::sine_at(i, AW, DW));
  end

  for (genvar r = 0; r < NRD; r++) begin : g_port
    assign rd_data[r] = table_w[rd_addr[r]];
  end
endmodule

// File: rtl/thi_mix.sv
module thi_mix #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_en,
  input  logic signed [DW-1:0] fund_i,
  input  logic signed [DW-1:0] harm_i,
  input  logic [DW-1:0]        m_i,
  input  logic [DW-1:0]        k_i,
  input  logic                 inj_i,
  output logic signed [DW-1:0] ref_o
);
  localparam int FB = DW - 1;
  localparam int PW = 2 * DW + 1;
  localparam int SW = PW + 1;
  localparam int MW = SW + DW + 1;
  localparam logic signed [MW-1:0] SMAX = MW'((1 << FB) - 1);
  localparam logic signed [MW-1:0] SMIN = -SMAX - 1;

  logic signed [DW:0]   k_s, m_s;
  logic signed [PW-1:0] kh, kh_sh;
  logic signed [SW-1:0] inner;
  logic signed [MW-1:0] prod, scaled;

  always_comb begin
    k_s    = inj_i ? $signed({1'b0, k_i}) : '0;
    m_s    = $signed({1'b0, m_i});
    kh     = PW'(k_s) * PW'(harm_i);
    kh_sh  = kh >>> FB;
    inner  = SW'(fund_i) + SW'(kh_sh);
    prod   = MW'(m_s) * MW'(inner);
    scaled = prod >>> FB;
    if (scaled > SMAX)      ref_o = SMAX[DW-1:0];
    else if (scaled < SMIN) ref_o = SMIN[DW-1:0];
    else                    ref_o = scaled[DW-1:0];
  end

  // R7: clamping keeps the sign of the unclamped result
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> ((scaled < 0) == ref_o[DW-1]));
endmodule

// File: rtl/thi_ref_gen.sv
module thi_ref_gen #(
  parameter int ACC_W      = 32,
  parameter int AW         = 10,
  parameter int DW         = 16,
  parameter int SAMPLE_DIV = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ACC_W-1:0]     phase_inc,
  input  logic [DW-1:0]        mod_idx,
  input  logic [DW-1:0]        harm_coef,
  input  logic                 inject_en,
  output logic signed [DW-1:0] ref_a,
  output logic signed [DW-1:0] ref_b,
  output logic signed [DW-1:0] ref_c,
  output logic                 ref_vld
);
  import thi_pkg::*;

  localparam int NRD = NPH + 1;
  localparam logic [ACC_W-1:0] THIRD = {ACC_W{1'b1}} / 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic             tick;
  logic [ACC_W-1:0] phase;
  logic [DW-1:0]    m_l, k_l;
  logic             inj_l;

  thi_phase_acc #(.ACC_W(ACC_W), .DW(DW), .SAMPLE_DIV(SAMPLE_DIV)) u_acc (
    .clk(clk), .rst_n(rst_s), .inc_i(phase_inc), .m_i(mod_idx), .k_i(harm_coef),
    .inj_i(inject_en), .tick_o(tick), .phase_o(phase), .m_o(m_l), .k_o(k_l),
    .inj_o(inj_l));

  // table addresses: three offset fundamentals plus the tripled angle
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;
  logic [ACC_W-1:0]       ph_off [NPH];
  logic [ACC_W-1:0]       ph3;

  for (genvar p = 0; p < NPH; p++) begin : g_addr
    assign ph_off[p]  = phase + ACC_W'(p) * THIRD;
    assign rd_addr[p] = ph_off[p][ACC_W-1 -: AW];
  end
  assign ph3          = phase + (phase << 1);
  assign rd_addr[NPH] = ph3[ACC_W-1 -: AW];

  thi_sine_rom #(.AW(AW), .DW(DW), .NRD(NRD)) u_rom (
    .rd_addr(rd_addr), .rd_data(rd_data));

  // stage 1: registered lookups
  logic                 s1_vld_q, s1_vld_d;
  logic                 s2_vld_q, s2_vld_d;
  logic [NRD-1:0][DW-1:0] lk_q, lk_d;

  always_comb begin
    s1_vld_d = tick;
    s2_vld_d = s1_vld_q;
    lk_d     = s1_vld_q ? rd_data : lk_q;
  end

  // stage 2: mix and clamp
  logic signed [DW-1:0] mix_w [NPH];
  for (genvar p = 0; p < NPH; p++) begin : g_mix
    thi_mix #(.DW(DW)) u_mix (
      .clk(clk), .rst_n(rst_s), .chk_en(s2_vld_q),
      .fund_i($signed(lk_q[p])), .harm_i($signed(lk_q[NPH])),
      .m_i(m_l), .k_i(k_l), .inj_i(inj_l), .ref_o(mix_w[p]));
  end

  logic signed [DW-1:0] out_q [NPH];
  logic signed [DW-1:0] out_d [NPH];
  logic                 vld_q, vld_d;

  always_comb begin
    vld_d = s2_vld_q;
    for (int p = 0; p < NPH; p++) out_d[p] = s2_vld_q ? mix_w[p] : out_q[p];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      lk_q     <= '0;
      vld_q    <= 1'b0;
      for (int p = 0; p < NPH; p++) out_q[p] <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s2_vld_q <= s2_vld_d;
      lk_q     <= lk_d;
      vld_q    <= vld_d;
      for (int p = 0; p < NPH; p++) out_q[p] <= out_d[p];
    end
  end

  assign ref_a   = out_q[0];
  assign ref_b   = out_q[1];
  assign ref_c   = out_q[2];
  assign ref_vld = vld_q;

  // R8: strobe lasts one cycle
  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rst_s)
    ref_vld |=> !ref_vld);
  // R8: outputs hold while no strobe
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !ref_vld |-> ($stable(ref_a) && $stable(ref_b) && $stable(ref_c)));
endmodule

// File: tb/thi_ref_gen_bench.sv
module thi_ref_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam real PI        = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] phase_inc;
  logic [15:0] mod_idx, harm_coef;
  logic        inject_en;
  logic signed [15:0] ref_a, ref_b, ref_c;
  logic        ref_vld;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thi_ref_gen #(.SAMPLE_DIV(DIV)) u_thi_ref_gen (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .mod_idx(mod_idx),
    .harm_coef(harm_coef), .inject_en(inject_en), .ref_a(ref_a), .ref_b(ref_b),
    .ref_c(ref_c), .ref_vld(ref_vld));

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_vld_cyc = -1;
  int sat_seen = 0;
  logic [31:0] ph_m = '0;
  logic [31:0] inc_m;
  int m_m, k_m;
  bit inj_m;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lutv(logic [31:0] ph);
    int idx;
    idx = int'(ph[31:22]);
    return int'(32767.0 * $sin(2.0 * PI * real'(idx) / 1024.0));
  endfunction

  function automatic int exp_ref(logic [31:0] ph, logic [31:0] off, int m, int k, bit inj);
    logic [31:0] p3;
    longint f, h, kh, inner, p;
    p3 = ph * 32'd3;
    f  = lutv(ph + off);
    h  = lutv(p3);
    kh = inj ? ((longint'(k) * h) >>> 15) : 0;
    inner = f + kh;
    p = (longint'(m) * inner) >>> 15;
    if (p > 32767)  return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  task automatic check(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic drive(logic [31:0] inc, int m, int k, bit inj);
    phase_inc = inc; mod_idx = 16'(m); harm_coef = 16'(k); inject_en = inj;
    inc_m = inc; m_m = m; k_m = k; inj_m = inj;
  endtask

  // waits for a strobe (sampled at negedge), checks it, then one more negedge
  task automatic sample(string tag);
    int ea, eb, ec;
    int guard = 0;
    while (ref_vld !== 1'b1 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 100) begin
      fails++; tests++;
      $display("FAIL R8: actual no strobe expected strobe within %0d cycles", DIV);
      return;
    end
    if (last_vld_cyc >= 0) check("R8 spacing", cyc - last_vld_cyc, DIV);
    last_vld_cyc = cyc;
    ph_m = ph_m + inc_m;
    ea = exp_ref(ph_m, 32'h0, m_m, k_m, inj_m);
    eb = exp_ref(ph_m, 32'h5555_5555, m_m, k_m, inj_m);
    ec = exp_ref(ph_m, 32'hAAAA_AAAA, m_m, k_m, inj_m);
    if (ea == 32767 || ea == -32768) sat_seen++;
    check({tag, " A"}, int'(ref_a), ea);
    check({tag, " B R3"}, int'(ref_b), eb);
    check({tag, " C R3"}, int'(ref_c), ec);
    @(negedge clk);
    check("R8 one-cycle", int'(ref_vld), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    drive(32'h0123_4567, 16'h8000, 0, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 reset vld", int'(ref_vld), 0);
    check("R8 reset out", int'(ref_a), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 pre-strobe", int'(ref_b), 0);

    // R1 / R2: unit index, plain sine reads the table directly
    for (int i = 0; i < 24; i++) sample("R1 R2");
    // R4: unit index and unit coefficient give F + H exactly
    drive(32'h0765_4321, 16'h8000, 16'h8000, 1'b1);
    for (int i = 0; i < 20; i++) sample("R4");
    // R5: nominal coefficient range
    drive(32'h0012_3456, 16'h7000, 5000, 1'b1);
    for (int i = 0; i < 20; i++) sample("R5");
    // R6: coefficient ignored when injection is off
    drive(32'h0400_0000, 16'h6000, 16'hFFFF, 1'b0);
    for (int i = 0; i < 16; i++) sample("R6");
    // R7: overmodulation clamps both ways
    sat_seen = 0;
    drive(32'h0400_0000, 16'hFFFF, 16'h3000, 1'b1);
    for (int i = 0; i < 16; i++) sample("R7");
    tests++;
    if (sat_seen == 0) begin
      fails++;
      $display("FAIL R7: actual 0 clamped samples expected >0");
    end
    // R9: change after the tick must not touch the in-flight sample
    drive(32'h0300_0000, 16'h4000, 6000, 1'b1);
    sample("R9 setup");
    repeat (5) @(negedge clk);
    mod_idx = 16'h7FFF; harm_coef = 16'd0; inject_en = 1'b0;
    sample("R9 old values");
    m_m = 16'h7FFF; k_m = 0; inj_m = 1'b0;
    sample("R9 new values");
    // random mix, parameters updated right after each strobe
    for (int i = 0; i < 300; i++) begin
      int kr;
      kr = ($urandom % 4 == 0) ? int'($urandom % 65536) : 4915 + int'($urandom % 1640);
      drive((i % 5 == 0) ? $urandom : inc_m, int'($urandom % 65536), kr, bit'($urandom % 2));
      sample("R5 random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule